// File: doc/BRIEF.md
# Configuration Clock Source Switch

This block chooses the clock that runs the configuration logic. After power-on the free-running internal oscillator drives it. A decoded "use user clock" instruction strobe from the test access port moves the configuration clock to an external user clock pin. The move happens only if the oscillator is reported as enabled when the request arrives. The choice is held in a sticky latch. Any later instruction traffic leaves it alone. Only a "use oscillator" strobe or power-on reset clears it.

Both instruction strobes are one-cycle pulses in the TCK domain. Each one becomes a level toggle in that domain. The toggle is synchronized into the user clock domain, and the latch updates there. The selected clock leaves through a glitch-free multiplexer: one source's gate opens only after the other source's gate has closed. A second output gives a data clock at half the selected rate. A status flag shows the user clock as active. After a "use oscillator" strobe this flag stays set for a fixed number of user clock cycles. This is the drain period the user clock must keep running through.

Top module: `cfg_clk_switch`

## Requirements
- R1: A "use user clock" strobe taken while `osc_on` is high sets `usr_active` to 1, and `cfg_clk` then runs at the `usr_clk` period.
- R2: A "use user clock" strobe taken while `osc_on` is low has no effect: `usr_active` stays 0 and `cfg_clk` keeps the `osc_clk` period.
- R3: Once set, the selection stays set through idle time, through repeated "use user clock" strobes and through `osc_on` falling.
- R4: Only a "use oscillator" strobe or `por_n` low (asynchronous, active low) clears the selection. Out of reset `usr_active` is 0 and `cfg_clk` follows `osc_clk`.
- R5: After a "use oscillator" strobe clears the selection, `usr_active` stays 1 for exactly `DRAIN_CYCLES` (default 10) further `usr_clk` rising edges and then drops to 0.
- R6: `data_clk` toggles on every rising edge of `cfg_clk`, so its period is twice the period of the selected clock.
- R7: `cfg_clk` has no runt pulse through a switch in either direction. Every high or low phase lasts at least the shorter of the two source half-periods, and the two source gates are never open together.
- R8: Strobes are single TCK-cycle pulses. If both strobes arrive in the same TCK cycle, the "use oscillator" strobe wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Internal oscillator clock |
| usr_clk | input | 1 | External user clock |
| tck | input | 1 | Test access port clock; the strobes are valid on its rising edge |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| osc_on | input | 1 | High while the internal oscillator is enabled |
| use_usr_stb | input | 1 | Decoded "use user clock" instruction pulse |
| use_osc_stb | input | 1 | Decoded "use oscillator" instruction pulse |
| cfg_clk | output | 1 | Selected configuration clock |
| data_clk | output | 1 | Selected clock divided by two |
| usr_active | output | 1 | High while the user clock source is latched or still draining |

## Verification
Four properties are checked on every cycle:
- the two multiplexer gates are never open together;
- the flag rises only on an edge where the synchronized `osc_on` was high;
- the flag is always set while the user clock is selected;
- the flag falls exactly `DRAIN_CYCLES` user clock edges after the selection drops.

Some behaviour needs the bench's scenarios. These cover:
- the measured period of `cfg_clk` and `data_clk` before and after each switch;
- pulse widths on `cfg_clk`;
- the stickiness of the latch across idle time and `osc_on` changes;
- the win of the "use oscillator" strobe when both strobes coincide;
- clearing by power-on reset.

// File: rtl/cfg_clk_switch.sv
`timescale 1ns/1ps
module cfg_clk_switch #(
  parameter int DRAIN_CYCLES = 10
) (
  input  logic osc_clk,
  input  logic usr_clk,
  input  logic tck,
  input  logic por_n,
  input  logic osc_on,
  input  logic use_usr_stb,
  input  logic use_osc_stb,
  output logic cfg_clk,
  output logic data_clk,
  output logic usr_active
);
  localparam int CW = (DRAIN_CYCLES > 1) ? $clog2(DRAIN_CYCLES) : 1;

  logic en_tgl, dis_tgl;
  always_ff @(posedge tck or negedge por_n)
    if (!por_n) begin
      en_tgl  <= 1'b0;
      dis_tgl <= 1'b0;
    end else begin
      en_tgl  <= en_tgl ^ use_usr_stb;
      dis_tgl <= dis_tgl ^ use_osc_stb;
    end

  logic [2:0] en_s, dis_s;
  logic [1:0] osc_s;
  always_ff @(posedge usr_clk or negedge por_n)
    if (!por_n) begin
      en_s  <= '0;
      dis_s <= '0;
      osc_s <= '0;
    end else begin
      en_s  <= {en_s[1:0], en_tgl};
      dis_s <= {dis_s[1:0], dis_tgl};
      osc_s <= {osc_s[0], osc_on};
    end

  wire en_hit  = en_s[2] ^ en_s[1];
  wire dis_hit = dis_s[2] ^ dis_s[1];

  logic usr_sel, draining;
  logic [CW-1:0] cnt;
  always_ff @(posedge usr_clk or negedge por_n)
    if (!por_n) begin
      usr_sel    <= 1'b0;
      usr_active <= 1'b0;
      draining   <= 1'b0;
      cnt        <= '0;
    end else if (dis_hit) begin
      usr_sel <= 1'b0;
      if (!draining) begin
        draining <= usr_active;
        cnt      <= '0;
      end
    end else if (en_hit && osc_s[1]) begin
      usr_sel    <= 1'b1;
      usr_active <= 1'b1;
      draining   <= 1'b0;
    end else if (draining) begin
      if (cnt == CW'(DRAIN_CYCLES - 1)) begin
        draining   <= 1'b0;
        usr_active <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end

  logic [1:0] u_g, o_g;
  always_ff @(negedge usr_clk or negedge por_n)
    if (!por_n) u_g <= '0;
    else        u_g <= {u_g[0], usr_sel & ~o_g[1]};

  always_ff @(negedge osc_clk or negedge por_n)
    if (!por_n) o_g <= '0;
    else        o_g <= {o_g[0], ~usr_sel & ~u_g[1]};

  assign cfg_clk = (usr_clk & u_g[1]) | (osc_clk & o_g[1]);

  always_ff @(posedge cfg_clk or negedge por_n)
    if (!por_n) data_clk <= 1'b0;
    else        data_clk <= ~data_clk;
endmodule

// File: rtl/cfg_clk_switch_chk.sv
`timescale 1ns/1ps
module cfg_clk_switch_chk #(
  parameter int DRAIN_CYCLES = 10
) (
  input logic usr_clk,
  input logic osc_clk,
  input logic por_n,
  input logic usr_sel,
  input logic usr_active,
  input logic osc_sync,
  input logic u_on,
  input logic o_on
);
  localparam int CCW = $clog2(DRAIN_CYCLES + 2);
  logic [CCW-1:0] since_drop;
  always_ff @(posedge usr_clk or negedge por_n)
    if (!por_n)                                    since_drop <= '0;
    else if (usr_sel)                              since_drop <= '0;
    else if (since_drop != CCW'(DRAIN_CYCLES + 1)) since_drop <= since_drop + 1'b1;

  assert_gates_apart_osc_R7: assert property (@(posedge osc_clk) disable iff (!por_n)
    !(u_on && o_on));
  assert_gates_apart_usr_R7: assert property (@(posedge usr_clk) disable iff (!por_n)
    !(u_on && o_on));
  assert_need_osc_R2: assert property (@(posedge usr_clk) disable iff (!por_n)
    $rose(usr_active) |-> $past(osc_sync));
  assert_sel_flagged_R1: assert property (@(posedge usr_clk) disable iff (!por_n)
    usr_sel |-> usr_active);
  assert_drain_len_R5: assert property (@(posedge usr_clk) disable iff (!por_n)
    $fell(usr_active) |-> since_drop == CCW'(DRAIN_CYCLES));
endmodule

bind cfg_clk_switch cfg_clk_switch_chk #(.DRAIN_CYCLES(DRAIN_CYCLES)) chk (
  .usr_clk(usr_clk), .osc_clk(osc_clk), .por_n(por_n), .usr_sel(usr_sel),
  .usr_active(usr_active), .osc_sync(osc_s[1]), .u_on(u_g[1]), .o_on(o_g[1]));

// File: tb/cfg_clk_switch_test.sv
`timescale 1ns/1ps
module cfg_clk_switch_test;
  logic osc_clk = 0, usr_clk = 0, tck = 0, por_n = 0, osc_on = 1;
  logic use_usr_stb = 0, use_osc_stb = 0;
  logic cfg_clk, data_clk, usr_active;
  int checks = 0, fails = 0, runts = 0;
  bit done = 0, mon_armed = 0;
  realtime last_edge = 0;

  localparam int OSC_PS = 5000, USR_PS = 13000;

  always #2.5 osc_clk = ~osc_clk;
  always #6.5 usr_clk = ~usr_clk;
  always #20  tck = ~tck;

  cfg_clk_switch uut (.osc_clk(osc_clk), .usr_clk(usr_clk), .tck(tck), .por_n(por_n),
    .osc_on(osc_on), .use_usr_stb(use_usr_stb), .use_osc_stb(use_osc_stb),
    .cfg_clk(cfg_clk), .data_clk(data_clk), .usr_active(usr_active));

  // R7 runt monitor: every phase of cfg_clk must last at least 2.5 ns
  always @(cfg_clk) begin
    if (por_n && mon_armed && ($realtime - last_edge) < 2.4) runts++;
    if (por_n) mon_armed = 1;
    last_edge = $realtime;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic period(input bit use_data, output int ps);
    realtime t0;
    if (use_data) begin @(posedge data_clk); t0 = $realtime; @(posedge data_clk); end
    else          begin @(posedge cfg_clk);  t0 = $realtime; @(posedge cfg_clk);  end
    ps = int'(($realtime - t0) * 1000.0);
  endtask

  task automatic pulse(input bit en, input bit dis);
    @(negedge tck); use_usr_stb = en; use_osc_stb = dis;
    @(negedge tck); use_usr_stb = 0; use_osc_stb = 0;
  endtask

  task automatic check_sel(input string tag, input bit exp_act);
    int p, pd, exp_p;
    exp_p = exp_act ? USR_PS : OSC_PS;
    chk(usr_active == exp_act, {tag, " usr_active"}, usr_active, exp_act);
    period(0, p);
    chk(p > exp_p - 100 && p < exp_p + 100, {tag, " cfg_clk period ps"}, p, exp_p);
    period(1, pd);
    chk(pd > 2*exp_p - 100 && pd < 2*exp_p + 100, "R6 data_clk period ps", pd, 2*exp_p);
  endtask

  // {req[3:0], op[1:0], osc_on, expected usr_active}; op 0 idle, 1 use-user, 2 use-osc, 3 both
  localparam int NV = 10;
  localparam logic [7:0] VEC [NV] = '{
    {4'd2, 2'd1, 1'b0, 1'b0},   // R2 request ignored, oscillator off
    {4'd1, 2'd1, 1'b1, 1'b1},   // R1 switch to user clock
    {4'd3, 2'd0, 1'b1, 1'b1},   // R3 idle keeps selection
    {4'd3, 2'd1, 1'b1, 1'b1},   // R3 repeated request
    {4'd3, 2'd0, 1'b0, 1'b1},   // R3 osc_on falls, still held
    {4'd4, 2'd2, 1'b0, 1'b0},   // R4 hand back
    {4'd4, 2'd2, 1'b1, 1'b0},   // R4 second hand back harmless
    {4'd1, 2'd1, 1'b1, 1'b1},   // R1 switch again
    {4'd8, 2'd3, 1'b1, 1'b0},   // R8 both strobes, hand back wins
    {4'd8, 2'd3, 1'b1, 1'b0}    // R8 both strobes while inactive
  };

  initial begin
    #100 por_n = 1;
    repeat (20) @(posedge osc_clk);
    #1;
    check_sel("R4 reset state", 1'b0);

    foreach (VEC[i]) begin
      string tag;
      tag = $sformatf("R%0d vector %0d", VEC[i][7:4], i);
      osc_on = VEC[i][1];
      repeat (3) @(posedge usr_clk);
      pulse(VEC[i][3:2] != 2'd0 && VEC[i][3:2] != 2'd2, VEC[i][3]);
      repeat (30) @(posedge usr_clk);
      #1;
      check_sel(tag, VEC[i][0]);
    end
    chk(runts == 0, "R7 runts after table", runts, 0);

    // R5 drain length, counted from the tck edge that carries the strobe
    osc_on = 1;
    pulse(1, 0);
    repeat (30) @(posedge usr_clk);
    @(negedge tck); use_osc_stb = 1;
    @(posedge tck); #1 use_osc_stb = 0;
    repeat (11) @(posedge usr_clk);
    #1 chk(usr_active == 1, "R5 flag held during drain", usr_active, 1);
    repeat (3) @(posedge usr_clk);
    #1 chk(usr_active == 0, "R5 flag dropped after drain", usr_active, 0);
    repeat (10) @(posedge usr_clk);
    #1 check_sel("R5 oscillator back", 1'b0);

    // R4 power-on reset clears an active selection
    pulse(1, 0);
    repeat (30) @(posedge usr_clk);
    #1 chk(usr_active == 1, "R4 selected before reset", usr_active, 1);
    mon_armed = 0;
    por_n = 0; #50 por_n = 1;
    #1 chk(usr_active == 0, "R4 cleared by reset", usr_active, 0);
    repeat (20) @(posedge osc_clk);
    #1 check_sel("R4 after reset", 1'b0);

    chk(runts == 0, "R7 runts at end", runts, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule